// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it is shown the instruction in decode: its class (no-op, ALU, load or store) and its three register fields. It keeps a shadow of the class and destination of the instructions further down the pipe. From register comparisons made in decode it produces registered bypass selects for both execute operands and a registered select for the store write data in the memory stage. It also raises the holds and bubbles that the surrounding pipeline registers obey.

A load whose result is needed in execute by the next instruction costs one stall cycle. A load followed by a store of the loaded value costs none, because the store data path in the memory stage picks the writeback result. When instruction and data memory share one port (parameter `SHARED_PORT`), any load or store in the memory stage blocks that cycle's fetch. The fetch slot then turns into a bubble in the fetch/decode register.

Field use by class: ALU reads `src_a` and `src_b` and writes `dst`. A load reads `src_a` (base) and writes `dst`. A store reads `src_a` (base) and `src_b` (data) and writes nothing. A no-op uses no field. Class codes are 0 no-op, 1 ALU, 2 load, 3 store.

Top module: `hazard_ctl`

## Requirements
- R1: An ALU result is bypassed to the next instruction that reads it (as ALU operand, load/store base or store data) with no stall: the matching operand select shows 2'b10 in the cycle after that instruction sits in decode.
- R2: When the instruction in execute is a load and the instruction in decode reads its destination as `src_a` (any non-no-op class) or as ALU `src_b`, exactly one stall cycle is inserted. After it, the select for that operand is 2'b01.
- R3: A store whose `src_b` equals the destination of the load directly ahead of it is not stalled. `st_data_wb_sel` is 1 (take writeback result) in the cycle the store is in the memory stage, and 0 otherwise.
- R4: With `SHARED_PORT`=1, while a load or store is in the memory stage, `pc_hold` is 1. `ifid_bubble` is 1 unless a load-use stall holds decode that cycle.
- R5: Operand selects are registered: they are decided with decode and appear the following cycle, when the instruction is in execute.
- R6: Register 0 never counts as a producer, so a read of register 0 always gets select 2'b00.
- R7: When both the execute-stage and the memory-stage instruction write the register read, the execute-stage (younger) one wins: select 2'b10.
- R8: During a load-use stall, `pc_hold`, `ifid_hold` and `idex_bubble` are 1 and `ifid_bubble` is 0. The bubble entering execute carries selects 2'b00 and writes no register.
- R9: Select codes are 2'b00 register file, 2'b01 memory/writeback result, 2'b10 execute/memory result; 2'b11 never appears.
- R10: A store never acts as a producer, whatever its `dst` field holds.
- R11: A producer already in writeback is not bypassed; the register file supplies it (select 2'b00).
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_cls | input | 2 | Class of the instruction in decode |
| id_src_a | input | REG_W | ALU operand A or load/store base register |
| id_src_b | input | REG_W | ALU operand B or store data register |
| id_dst | input | REG_W | Destination register |
| fwd_a_sel | output | 2 | Operand A bypass select for execute |
| fwd_b_sel | output | 2 | Operand B / store data bypass select for execute |
| st_data_wb_sel | output | 1 | Memory-stage store data takes writeback result |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| ifid_bubble | output | 1 | Load a no-op into the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The bench targets pairs that differ only in which field carries the dependence. Load-then-store-data must not stall, while load-then-store-base must stall once; a design that mixes up the two fields would either lose a cycle or read stale data. Register 0 and store destinations are fed as apparent producers; a design that matches them would emit a nonzero select and corrupt an operand. A twice-written register checks that the younger producer wins, and a port conflict that overlaps a load-use stall checks that decode is held rather than bubbled, which would otherwise drop an instruction.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    CLS_NOP   = 2'd0,
    CLS_ALU   = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } icls_e;

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  localparam int N_OPS = 2;
endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  icls_e            id_cls,
  input  logic [REG_W-1:0] id_dst,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             kill,
  output icls_e            ex_cls,
  output logic [REG_W-1:0] ex_dst,
  output logic [REG_W-1:0] ex_src_b,
  output logic             ex_wr,
  output icls_e            mem_cls,
  output logic [REG_W-1:0] mem_dst,
  output logic             mem_wr
);
  icls_e            ex_cls_nxt, mem_cls_nxt;
  logic [REG_W-1:0] ex_dst_nxt, ex_src_b_nxt, mem_dst_nxt;
  logic             ex_wr_nxt, mem_wr_nxt, id_wr;

  always_comb begin
    id_wr = ((id_cls == CLS_ALU) || (id_cls == CLS_LOAD)) && (id_dst != '0);
    if (kill) begin
      ex_cls_nxt   = CLS_NOP;
      ex_dst_nxt   = '0;
      ex_src_b_nxt = '0;
      ex_wr_nxt    = 1'b0;
    end else begin
      ex_cls_nxt   = id_cls;
      ex_dst_nxt   = id_dst;
      ex_src_b_nxt = id_src_b;
      ex_wr_nxt    = id_wr;
    end
    mem_cls_nxt = ex_cls;
    mem_dst_nxt = ex_dst;
    mem_wr_nxt  = ex_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_cls   <= CLS_NOP;
      ex_dst   <= '0;
      ex_src_b <= '0;
      ex_wr    <= 1'b0;
      mem_cls  <= CLS_NOP;
      mem_dst  <= '0;
      mem_wr   <= 1'b0;
    end else begin
      ex_cls   <= ex_cls_nxt;
      ex_dst   <= ex_dst_nxt;
      ex_src_b <= ex_src_b_nxt;
      ex_wr    <= ex_wr_nxt;
      mem_cls  <= mem_cls_nxt;
      mem_dst  <= mem_dst_nxt;
      mem_wr   <= mem_wr_nxt;
    end
  end

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wr |-> (ex_dst != '0));
  // R10
  store_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_cls == CLS_STORE) |-> !ex_wr);
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic             kill,
  input  logic             ex_wr,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_wr,
  input  logic [REG_W-1:0] mem_dst,
  output logic [1:0]       sel_nxt
);
  logic hit_ex, hit_mem;

  always_comb begin
    hit_ex  = used && ex_wr && !ex_is_load && (ex_dst == src);
    hit_mem = used && mem_wr && (mem_dst == src);
    if (kill)         sel_nxt = SEL_RF;
    else if (hit_ex)  sel_nxt = SEL_MEM;
    else if (hit_mem) sel_nxt = SEL_WB;
    else              sel_nxt = SEL_RF;
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter bit SHARED_PORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  icls_e            id_cls,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  icls_e            ex_cls,
  input  logic [REG_W-1:0] ex_dst,
  input  icls_e            mem_cls,
  output logic             lu_stall,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             ifid_bubble,
  output logic             idex_bubble
);
  logic port_busy, need_a, need_b;

  generate
    if (SHARED_PORT) begin : g_shared
      always_comb port_busy = (mem_cls == CLS_LOAD) || (mem_cls == CLS_STORE);
    end else begin : g_split
      always_comb port_busy = 1'b0;
    end
  endgenerate

  always_comb begin
    need_a   = (id_cls != CLS_NOP) && (id_src_a == ex_dst);
    need_b   = (id_cls == CLS_ALU) && (id_src_b == ex_dst);
    lu_stall = (ex_cls == CLS_LOAD) && (ex_dst != '0) && (need_a || need_b);
    pc_hold     = lu_stall || port_busy;
    ifid_hold   = lu_stall;
    ifid_bubble = port_busy && !lu_stall;
    idex_bubble = lu_stall;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (ifid_hold && pc_hold && !ifid_bubble));
  // R4
  port_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_bubble |-> (pc_hold && !ifid_hold));
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter bit SHARED_PORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       id_cls,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] id_dst,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             st_data_wb_sel,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             ifid_bubble,
  output logic             idex_bubble
);
  icls_e            cls_q;
  icls_e            ex_cls, mem_cls;
  logic [REG_W-1:0] ex_dst, ex_src_b, mem_dst;
  logic             ex_wr, mem_wr, lu_stall;
  logic [REG_W-1:0] op_src [N_OPS];
  logic             op_use [N_OPS];
  logic [1:0]       op_sel [N_OPS];
  logic [1:0]       fwd_a_nxt, fwd_b_nxt;
  logic             sd_nxt;

  always_comb cls_q = icls_e'(id_cls);

  hz_stage_track #(.REG_W(REG_W)) trk_i (
    .clk(clk), .rst_n(rst_n), .id_cls(cls_q), .id_dst(id_dst),
    .id_src_b(id_src_b), .kill(lu_stall),
    .ex_cls(ex_cls), .ex_dst(ex_dst), .ex_src_b(ex_src_b), .ex_wr(ex_wr),
    .mem_cls(mem_cls), .mem_dst(mem_dst), .mem_wr(mem_wr)
  );

  hz_stall_unit #(.REG_W(REG_W), .SHARED_PORT(SHARED_PORT)) stl_i (
    .clk(clk), .rst_n(rst_n), .id_cls(cls_q), .id_src_a(id_src_a),
    .id_src_b(id_src_b), .ex_cls(ex_cls), .ex_dst(ex_dst), .mem_cls(mem_cls),
    .lu_stall(lu_stall), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ifid_bubble(ifid_bubble), .idex_bubble(idex_bubble)
  );

  always_comb begin
    op_src[0] = id_src_a;
    op_use[0] = (cls_q != CLS_NOP);
    op_src[1] = id_src_b;
    op_use[1] = (cls_q == CLS_ALU) || (cls_q == CLS_STORE);
  end

  generate
    for (genvar k = 0; k < N_OPS; k++) begin : g_op
      hz_fwd_pick #(.REG_W(REG_W)) pick_i (
        .src(op_src[k]), .used(op_use[k]), .kill(lu_stall),
        .ex_wr(ex_wr), .ex_is_load(ex_cls == CLS_LOAD), .ex_dst(ex_dst),
        .mem_wr(mem_wr), .mem_dst(mem_dst), .sel_nxt(op_sel[k])
      );
    end
  endgenerate

  always_comb begin
    fwd_a_nxt = op_sel[0];
    fwd_b_nxt = op_sel[1];
    sd_nxt    = (ex_cls == CLS_STORE) && (mem_cls == CLS_LOAD) &&
                mem_wr && (mem_dst == ex_src_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_a_sel      <= SEL_RF;
      fwd_b_sel      <= SEL_RF;
      st_data_wb_sel <= 1'b0;
    end else begin
      fwd_a_sel      <= fwd_a_nxt;
      fwd_b_sel      <= fwd_b_nxt;
      st_data_wb_sel <= sd_nxt;
    end
  end

  // R2
  one_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> !idex_bubble);
  // R8
  bubble_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> (fwd_a_sel == SEL_RF && fwd_b_sel == SEL_RF));
  // R9
  sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));
endmodule

// File: tb/hazard_ctl_tb_top.sv
module hazard_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  typedef struct packed {
    logic [1:0]    c;
    logic [RW-1:0] a;
    logic [RW-1:0] b;
    logic [RW-1:0] d;
  } ins_t;

  localparam logic [1:0] NOP = 2'd0, ALU = 2'd1, LD = 2'd2, ST = 2'd3;
  localparam ins_t BUBBLE = '0;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] id_cls;
  logic [RW-1:0] id_src_a, id_src_b, id_dst;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic st_data_wb_sel, pc_hold, ifid_hold, ifid_bubble, idex_bubble;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctl #(.REG_W(RW), .SHARED_PORT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_cls(id_cls), .id_src_a(id_src_a),
    .id_src_b(id_src_b), .id_dst(id_dst), .fwd_a_sel(fwd_a_sel),
    .fwd_b_sel(fwd_b_sel), .st_data_wb_sel(st_data_wb_sel),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ifid_bubble(ifid_bubble),
    .idex_bubble(idex_bubble)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  ins_t prog [16];
  int   plen, pc;
  ins_t ifid, m_ex, m_mem;
  logic [1:0] r_fa, r_fb;
  logic r_sd;
  int n_lu, n_bub, n_sd, n_fa2, n_fa1, n_fb2, n_fb1;

  function automatic bit f_wr(ins_t i);
    return ((i.c == ALU) || (i.c == LD)) && (i.d != 0);
  endfunction

  function automatic bit f_lu(ins_t id, ins_t ex);
    if (ex.c != LD || ex.d == 0) return 0;
    return ((id.c != NOP) && (id.a == ex.d)) || ((id.c == ALU) && (id.b == ex.d));
  endfunction

  function automatic logic [1:0] f_sel(logic [RW-1:0] s, bit used, ins_t ex, ins_t mem);
    if (!used) return 2'b00;
    if (f_wr(ex) && ex.c != LD && ex.d == s) return 2'b10;
    if (f_wr(mem) && mem.d == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_id();
    id_cls = ifid.c; id_src_a = ifid.a; id_src_b = ifid.b; id_dst = ifid.d;
  endtask

  task automatic step();
    bit e_lu, e_port;
    logic [1:0] n_fa, n_fb;
    bit n_sdv;
    @(negedge clk);
    e_lu   = f_lu(ifid, m_ex);
    e_port = (m_mem.c == LD) || (m_mem.c == ST);
    chk("R4 pc_hold", pc_hold, e_lu | e_port);
    chk("R8 ifid_hold", ifid_hold, e_lu);
    chk("R4 ifid_bubble", ifid_bubble, e_port & !e_lu);
    chk("R2 idex_bubble", idex_bubble, e_lu);
    chk("R5 fwd_a_sel", fwd_a_sel, r_fa);
    chk("R5 fwd_b_sel", fwd_b_sel, r_fb);
    chk("R3 st_data_wb_sel", st_data_wb_sel, r_sd);
    n_lu  += int'(idex_bubble);
    n_bub += int'(ifid_bubble);
    n_sd  += int'(st_data_wb_sel);
    n_fa2 += int'(fwd_a_sel == 2'b10);
    n_fa1 += int'(fwd_a_sel == 2'b01);
    n_fb2 += int'(fwd_b_sel == 2'b10);
    n_fb1 += int'(fwd_b_sel == 2'b01);
    n_fa  = e_lu ? 2'b00 : f_sel(ifid.a, ifid.c != NOP, m_ex, m_mem);
    n_fb  = e_lu ? 2'b00 : f_sel(ifid.b, (ifid.c == ALU) || (ifid.c == ST), m_ex, m_mem);
    n_sdv = (m_ex.c == ST) && (m_mem.c == LD) && f_wr(m_mem) && (m_mem.d == m_ex.b);
    @(posedge clk);
    #1;
    r_fa = n_fa; r_fb = n_fb; r_sd = n_sdv;
    m_mem = m_ex;
    m_ex  = e_lu ? BUBBLE : ifid;
    if (!e_lu) begin
      if (e_port) ifid = BUBBLE;
      else begin
        ifid = (pc < plen) ? prog[pc] : BUBBLE;
        pc++;
      end
    end
    drive_id();
  endtask

  task automatic run(int n);
    plen = n; pc = 0;
    n_lu = 0; n_bub = 0; n_sd = 0; n_fa2 = 0; n_fa1 = 0; n_fb2 = 0; n_fb1 = 0;
    while (pc < plen + 5) step();
  endtask

  function automatic ins_t mk(logic [1:0] c, int a, int b, int d);
    ins_t i;
    i.c = c; i.a = RW'(a); i.b = RW'(b); i.d = RW'(d);
    return i;
  endfunction

  initial begin
    int seed;
    rst_n = 1'b0;
    ifid = BUBBLE; m_ex = BUBBLE; m_mem = BUBBLE;
    r_fa = 0; r_fb = 0; r_sd = 0; plen = 0; pc = 0;
    drive_id();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 reset fwd_a", fwd_a_sel, 0);
    chk("R12 reset fwd_b", fwd_b_sel, 0);
    chk("R12 reset holds", {pc_hold, ifid_hold, ifid_bubble, idex_bubble, st_data_wb_sel}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 add -> add
    prog[0] = mk(ALU, 2, 3, 1); prog[1] = mk(ALU, 1, 5, 4); run(2);
    chk("R1 add-add fwd_a=10 count", n_fa2, 1); chk("R1 add-add stalls", n_lu, 0);
    // R1 add -> lw base
    prog[0] = mk(ALU, 2, 3, 1); prog[1] = mk(LD, 1, 0, 4); run(2);
    chk("R1 add-lw base fwd_a=10 count", n_fa2, 1); chk("R1 add-lw stalls", n_lu, 0);
    // R2 lw -> add (operand B)
    prog[0] = mk(LD, 2, 0, 1); prog[1] = mk(ALU, 4, 1, 3); run(2);
    chk("R2 lw-add stalls", n_lu, 1); chk("R2 lw-add fwd_b=01 count", n_fb1, 1);
    // R2 lw -> lw base
    prog[0] = mk(LD, 2, 0, 1); prog[1] = mk(LD, 1, 0, 4); run(2);
    chk("R2 lw-lw stalls", n_lu, 1); chk("R2 lw-lw fwd_a=01 count", n_fa1, 1);
    // R3 lw -> sw data
    prog[0] = mk(LD, 2, 0, 1); prog[1] = mk(ST, 3, 1, 0); run(2);
    chk("R3 lw-sw data stalls", n_lu, 0); chk("R3 lw-sw data sd count", n_sd, 1);
    // R2 lw -> sw base
    prog[0] = mk(LD, 2, 0, 1); prog[1] = mk(ST, 1, 3, 0); run(2);
    chk("R2 lw-sw base stalls", n_lu, 1); chk("R2 lw-sw base sd count", n_sd, 0);
    // R4 port conflict
    prog[0] = mk(ST, 2, 3, 0); prog[1] = mk(ALU, 4, 5, 6); prog[2] = mk(ALU, 7, 8, 9); run(3);
    chk("R4 port bubble count", n_bub, 1);
    // R6 register 0
    prog[0] = mk(ALU, 2, 3, 0); prog[1] = mk(ALU, 0, 0, 4); run(2);
    chk("R6 r0 fwd count", n_fa2 + n_fb2 + n_fa1 + n_fb1, 0);
    // R10 store dst field ignored
    prog[0] = mk(ST, 2, 3, 1); prog[1] = mk(ALU, 1, 1, 4); run(2);
    chk("R10 store producer fwd count", n_fa2 + n_fb2 + n_fa1 + n_fb1, 0);
    // R7 youngest wins
    prog[0] = mk(ALU, 2, 3, 1); prog[1] = mk(ALU, 4, 5, 1); prog[2] = mk(ALU, 1, 0, 6); run(3);
    chk("R7 younger fwd_a=10", n_fa2, 1); chk("R7 older fwd_a=01", n_fa1, 0);
    // R11 writeback producer via register file
    prog[0] = mk(ALU, 2, 3, 1); prog[1] = mk(ALU, 4, 5, 6); prog[2] = mk(ALU, 7, 8, 9);
    prog[3] = mk(ALU, 1, 1, 10); run(4);
    chk("R11 wb producer no fwd", n_fa1 + n_fb1 + n_fa2 + n_fb2, 0);
    // R8 load-use overlapping port conflict
    prog[0] = mk(LD, 2, 0, 1); prog[1] = mk(LD, 3, 0, 4); prog[2] = mk(ALU, 4, 5, 6); run(3);
    chk("R8 overlap stalls", n_lu, 1);

    // random stimulus, small register space for dense hazards
    seed = $urandom(32'h5eed_1234);
    for (int blk = 0; blk < 80; blk++) begin
      for (int k = 0; k < 16; k++)
        prog[k] = mk(2'($urandom_range(3, 0)), $urandom_range(3, 0),
                     $urandom_range(3, 0), $urandom_range(3, 0));
      run(16);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule